// File: doc/BRIEF.md
# Header Template Field Patcher

The block keeps a bank of stored packet-header templates and turns each accepted request into an outgoing header. The outgoing header is sent as a stream of 32-bit words. A request names a template slot, a mode code, a header length in words, up to three 32-bit update words and a full header image. The mode selects one of three behaviours:

- **Pass:** send the supplied header unchanged.
- **Copy:** store the supplied header into the slot and send it.
- **Patch:** read the slot back and apply one, two or three update words before sending.

Each update word carries a 16-bit value, the header word it targets, a field start bit and a field length. One update word therefore rewrites a single bit field inside one header word and leaves the other bits alone. A stored template may be longer than the header being sent; the length in the request decides how many words leave the block. Requests are taken one at a time. A new request is accepted only after the last word of the previous one has been handed over on the output handshake.

Top module: `hdr_tpl_patcher`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid is 0 after that edge and req_ready is 1.
- R2: Mode 0 (pass) sends the words of req_hdr, word 0 first (word w is req_hdr[32w+31:32w]), and leaves every stored template unchanged.
- R3: Mode 1 (copy) writes all 16 words of req_hdr into slot req_slot (0 to 31). It also sends the supplied header.
- R4: Modes 2, 3 and 4 read slot req_slot and apply the first 1, 2 or 3 update words, where update k is req_upd[32k+31:32k]. Update words beyond that count have no effect.
- R5: The fields of an update word are:
  - bits 15:0: the value;
  - bits 19:16: the target header word;
  - bits 23:20: the field length;
  - bits 28:24: the start bit;
  - bit 31: enable.

  Bits 30:29 are ignored. The low length bits of the value replace bits start to start+length-1 of the target word. All other bits are kept.
- R6: An update word with bit 31 clear leaves the header unchanged.
- R7: A length code of 0 means a 16-bit field. A field that would extend past bit 31 is cut off at bit 31.
- R8: Update words are applied in list order, so where two of them touch the same bits the later one wins.
- R9: The number of words sent is req_hlen, limited to 16. A length of 0 sends nothing and completes at once, with req_ready still 1.
- R10: The output follows a valid/ready handshake:
  - out_data holds while out_valid is 1 and out_ready is 0;
  - out_last marks the final word;
  - req_ready is 0 whenever words are still pending.
- R11: Mode codes 5, 6 and 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_slot | input | 5 | Template slot |
| req_mode | input | 3 | Mode code |
| req_hlen | input | 5 | Header words to send |
| req_upd | input | 96 | Three update words, word 0 in bits 31:0 |
| req_hdr | input | 512 | Supplied header, word 0 in bits 31:0 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Header word |
| out_last | output | 1 | Final word of this header |

## Verification
A wrong internal state shows up in different ways depending on where it sits:

- **Corrupted stored template:** it stays hidden until that slot is patched. The bad word then appears at the word position it occupies, after the request is accepted.
- **Wrong word counter or length:** it shows within the same header, as a missing or extra word, a misplaced out_last, or req_ready returning too early or too late.
- **Wrong field mask or update order:** it shows only on the targeted word. For this reason the stimulus covers overlapping fields, a zero length code, fields cut off at bit 31, and disabled or surplus update words.

// File: rtl/hdr_tpl_pkg.sv
// Shared constants and the field-rewrite function of the template patcher.
// Assumes 32-bit header words and update words laid out as described in
// the requirements (value, word index, length, start, enable).
package hdr_tpl_pkg;
    localparam int WORD_W    = 32;
    localparam int VAL_LSB   = 0;
    localparam int IDX_LSB   = 16;
    localparam int LEN_LSB   = 20;
    localparam int START_LSB = 24;
    localparam int EN_BIT    = 31;

    typedef enum logic [2:0] {
        MODE_PASS = 3'd0,
        MODE_COPY = 3'd1,
        MODE_UPD1 = 3'd2,
        MODE_UPD2 = 3'd3,
        MODE_UPD3 = 3'd4
    } hdr_mode_e;

    // Rewrite one bit field of a header word as an update word directs.
    function automatic logic [WORD_W-1:0] apply_update(
        input logic [WORD_W-1:0] w,
        input logic [WORD_W-1:0] u
    );
        logic [4:0]        flen;
        logic [WORD_W-1:0] fmask;
        logic [WORD_W-1:0] smask;
        logic [WORD_W-1:0] ins;
        flen  = (u[LEN_LSB +: 4] == 4'd0) ? 5'd16 : {1'b0, u[LEN_LSB +: 4]};
        fmask = (32'd1 << flen) - 32'd1;
        smask = fmask << u[START_LSB +: 5];
        ins   = ({16'd0, u[VAL_LSB +: 16]} & fmask) << u[START_LSB +: 5];
        return (w & ~smask) | ins;
    endfunction
endpackage

// File: rtl/hdr_tpl_store.sv
// Template bank: SLOTS entries of WORDS header words each.
// A write replaces a whole entry in one cycle; the read is combinational.
// Assumes the contents of a slot are meaningful only after it was written.
module hdr_tpl_store #(
    parameter int SLOTS = 32,
    parameter int WORDS = 16,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int FRAME_W = WORDS * hdr_tpl_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic [SLOT_W-1:0]  rd_slot,
    output logic [FRAME_W-1:0] rd_data
);
    logic [FRAME_W-1:0] mem [SLOTS];

    // Store a whole template when a copy request is accepted.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot] <= wr_data;
    end

    // Present the addressed template to the patch logic.
    assign rd_data = mem[rd_slot];

    a_r3_copy_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_slot)] == $past(wr_data));
endmodule

// File: rtl/hdr_field_patch.sv
// Chain of NUPD field-rewrite stages over a full header image.
// Stage k is active only when k < use_cnt and its update word is enabled;
// later stages see earlier results, so the last writer of a bit wins.
// Assumes WORDS <= 16 so every word is reachable by the 4-bit index.
module hdr_field_patch #(
    parameter int WORDS = 16,
    parameter int NUPD  = 3,
    localparam int WW      = hdr_tpl_pkg::WORD_W,
    localparam int FRAME_W = WORDS * WW,
    localparam int CNT_W   = $clog2(NUPD + 1)
) (
    input  logic [FRAME_W-1:0]   base,
    input  logic [NUPD*WW-1:0]   upd,
    input  logic [CNT_W-1:0]     use_cnt,
    output logic [FRAME_W-1:0]   patched
);
    logic [WW-1:0] stage [NUPD+1][WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_in
        assign stage[0][w] = base[w*WW +: WW];
        assign patched[w*WW +: WW] = stage[NUPD][w];
    end

    for (genvar k = 0; k < NUPD; k++) begin : g_stage
        logic [WW-1:0] u;
        logic          live;
        assign u    = upd[k*WW +: WW];
        assign live = (CNT_W'(k) < use_cnt) && u[hdr_tpl_pkg::EN_BIT];
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign stage[k+1][w] =
                (live && u[hdr_tpl_pkg::IDX_LSB +: 4] == 4'(w))
                ? hdr_tpl_pkg::apply_update(stage[k][w], u)
                : stage[k][w];
        end
    end
endmodule

// File: rtl/hdr_word_emitter.sv
// Holds one finished header and sends its first len words over a
// valid/ready handshake, one word per accepted cycle.
// Assumes load arrives only while idle and with 1 <= load_len <= WORDS.
module hdr_word_emitter #(
    parameter int WORDS = 16,
    localparam int WW      = hdr_tpl_pkg::WORD_W,
    localparam int FRAME_W = WORDS * WW,
    localparam int LEN_W   = $clog2(WORDS + 1),
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [LEN_W-1:0]   load_len,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WW-1:0]      out_data,
    output logic               out_last
);
    logic [WW-1:0]    frame_q [WORDS];
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             valid_q;

    // Capture the header image on load.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int w = 0; w < WORDS; w++) frame_q[w] <= load_frame[w*WW +: WW];
        end
    end

    // Track the word position and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            cnt_q   <= '0;
            len_q   <= load_len;
        end else if (valid_q && out_ready) begin
            if (cnt_q == len_q - LEN_W'(1)) valid_q <= 1'b0;
            else                            cnt_q   <= cnt_q + LEN_W'(1);
        end
    end

    assign out_valid = valid_q;
    assign out_data  = frame_q[cnt_q[IDX_W-1:0]];
    assign out_last  = valid_q && (cnt_q == len_q - LEN_W'(1));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt_q < len_q && len_q <= LEN_W'(WORDS)));
    a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/hdr_tpl_patcher.sv
// Top of the header template patcher. Accepts one request when idle,
// builds the outgoing header in the accept cycle (pass, copy or patch of a
// stored template) and streams it out. Assumes WORDS <= 16 and NUPD <= 3
// so the mode code can name every update count.
module hdr_tpl_patcher #(
    parameter int SLOTS = 32,
    parameter int WORDS = 16,
    parameter int NUPD  = 3,
    localparam int WW      = hdr_tpl_pkg::WORD_W,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int FRAME_W = WORDS * WW,
    localparam int LEN_W   = $clog2(WORDS + 1),
    localparam int CNT_W   = $clog2(NUPD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SLOT_W-1:0]  req_slot,
    input  logic [2:0]         req_mode,
    input  logic [LEN_W-1:0]   req_hlen,
    input  logic [NUPD*WW-1:0] req_upd,
    input  logic [FRAME_W-1:0] req_hdr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WW-1:0]      out_data,
    output logic               out_last
);
    import hdr_tpl_pkg::*;

    logic               accept;
    logic               is_patch;
    logic [CNT_W-1:0]   use_cnt;
    logic [LEN_W-1:0]   hlen_eff;
    logic [FRAME_W-1:0] tpl_data;
    logic [FRAME_W-1:0] tpl_patched;
    logic [FRAME_W-1:0] frame;

    // Decode the request: handshake, update count and clamped length.
    always_comb begin
        accept   = req_valid && req_ready;
        is_patch = (req_mode >= MODE_UPD1) && (req_mode <= MODE_UPD3);
        use_cnt  = is_patch ? CNT_W'(req_mode - 3'd1) : '0;
        hlen_eff = (req_hlen > LEN_W'(WORDS)) ? LEN_W'(WORDS) : req_hlen;
        frame    = is_patch ? tpl_patched : req_hdr;
    end

    hdr_tpl_store #(.SLOTS(SLOTS), .WORDS(WORDS)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && req_mode == MODE_COPY),
        .wr_slot (req_slot),
        .wr_data (req_hdr),
        .rd_slot (req_slot),
        .rd_data (tpl_data)
    );

    hdr_field_patch #(.WORDS(WORDS), .NUPD(NUPD)) i_patch (
        .base    (tpl_data),
        .upd     (req_upd),
        .use_cnt (use_cnt),
        .patched (tpl_patched)
    );

    hdr_word_emitter #(.WORDS(WORDS)) i_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && hlen_eff != '0),
        .load_frame (frame),
        .load_len   (hlen_eff),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    // A new request is taken only when no word is pending.
    assign req_ready = !out_valid;

    a_r2_pass_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == MODE_PASS && req_hlen != '0)
        |=> (out_valid && out_data == $past(req_hdr[WW-1:0])));
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_hlen == '0) |=> (!out_valid && req_ready));
endmodule

// File: tb/test_hdr_tpl_patcher.sv
module test_hdr_tpl_patcher;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [4:0]   req_slot = '0;
    logic [2:0]   req_mode = '0;
    logic [4:0]   req_hlen = '0;
    logic [95:0]  req_upd = '0;
    logic [511:0] req_hdr = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_data;
    logic         out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R2";

    logic [511:0] tmem [32];
    logic [31:0]  exp_q [$];
    string        tag_q [$];

    always #5 clk = ~clk;

    hdr_tpl_patcher i_hdr_tpl_patcher (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_slot(req_slot), .req_mode(req_mode), .req_hlen(req_hlen),
        .req_upd(req_upd), .req_hdr(req_hdr), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [511:0] mkhdr(input int unsigned seed);
        logic [511:0] h;
        for (int w = 0; w < 16; w++)
            h[w*32 +: 32] = (seed * 32'h01000193) ^ (w * 32'h9E3779B9) ^ 32'h5A5A_0F0F;
        return h;
    endfunction

    function automatic logic [31:0] mkupd(input logic [15:0] val, input int idx,
        input int flen, input int start, input bit en, input logic [1:0] junk);
        return {en, junk, 5'(start), 4'(flen), 4'(idx), val};
    endfunction

    // Behavioural reference: bit by bit field replacement.
    function automatic logic [511:0] ref_patch(input logic [511:0] t,
                                                input logic [95:0] u, input int n);
        logic [511:0] r = t;
        for (int k = 0; k < n; k++) begin
            logic [31:0] uw = u[k*32 +: 32];
            if (uw[31]) begin
                int idx = int'(uw[19:16]);
                int fl  = (uw[23:20] == 0) ? 16 : int'(uw[23:20]);
                int st  = int'(uw[28:24]);
                for (int i = 0; i < fl; i++)
                    if (st + i < 32) r[idx*32 + st + i] = uw[i];
            end
        end
        return r;
    endfunction

    // Reference model and comparison, once per clock at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst_n) begin
            check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
            check("R1", "req_ready in reset", 32'(req_ready), 32'd1);
            exp_q.delete();
            tag_q.delete();
        end else begin
            check("R10", "req_ready", 32'(req_ready), 32'(exp_q.size() == 0));
            check("R10", "out_valid", 32'(out_valid), 32'(exp_q.size() != 0));
            if (out_valid && exp_q.size() != 0) begin
                check(tag_q[0], "out_data", out_data, exp_q[0]);
                check("R10", "out_last", 32'(out_last), 32'(exp_q.size() == 1));
                if (out_ready) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (req_valid && exp_q.size() == 0) begin
                logic [511:0] fr;
                int n;
                if (req_mode >= 2 && req_mode <= 4) fr = ref_patch(tmem[req_slot], req_upd, int'(req_mode) - 1);
                else fr = req_hdr;
                if (req_mode == 1) tmem[req_slot] = req_hdr;
                n = (req_hlen > 16) ? 16 : int'(req_hlen);
                for (int w = 0; w < n; w++) begin
                    exp_q.push_back(fr[w*32 +: 32]);
                    tag_q.push_back(cur_tag);
                end
            end
        end
    end

    // Output back-pressure pattern.
    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
    end

    task automatic send(input string tag, input int slot, input int mode,
                        input logic [31:0] u0, input logic [31:0] u1,
                        input logic [31:0] u2, input int hlen,
                        input logic [511:0] hdr);
        @(posedge clk); #2;
        cur_tag   = tag;
        req_valid = 1'b1;
        req_slot  = 5'(slot);
        req_mode  = 3'(mode);
        req_upd   = {u2, u1, u0};
        req_hlen  = 5'(hlen);
        req_hdr   = hdr;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R3: copy into two slots, full and partial length
        send("R3", 3, 1, 0, 0, 0, 16, mkhdr(11));
        send("R3", 31, 1, 0, 0, 0, 8, mkhdr(12));
        // R2: pass leaves storage intact, checked by a disabled patch (R6)
        send("R2", 3, 0, 0, 0, 0, 5, mkhdr(99));
        send("R6", 3, 2, mkupd(16'hFFFF, 1, 0, 0, 1'b0, 2'b00), 0, 0, 16, '0);
        // R5: field layout, junk bits 30:29 ignored
        send("R5", 3, 2, mkupd(16'hABCD, 2, 8, 4, 1'b1, 2'b11), 0, 0, 16, '0);
        // R4: two and three updates; surplus update words ignored in mode 2
        send("R4", 31, 3, mkupd(16'h1234, 0, 4, 0, 1'b1, 2'b00),
             mkupd(16'h00FF, 7, 8, 16, 1'b1, 2'b00), 0, 8, '0);
        send("R4", 3, 2, mkupd(16'h0001, 5, 1, 3, 1'b1, 2'b00),
             mkupd(16'hFFFF, 0, 0, 0, 1'b1, 2'b00), mkupd(16'hFFFF, 1, 0, 0, 1'b1, 2'b00), 16, '0);
        // R8: overlapping fields, last one wins
        send("R8", 3, 4, mkupd(16'hAAAA, 4, 0, 8, 1'b1, 2'b00),
             mkupd(16'h5555, 4, 8, 12, 1'b1, 2'b00), mkupd(16'h0003, 4, 2, 14, 1'b1, 2'b00), 6, '0);
        // R7: zero length code means 16 bits; field clipped at bit 31
        send("R7", 3, 2, mkupd(16'hBEEF, 9, 0, 0, 1'b1, 2'b00), 0, 0, 12, '0);
        send("R7", 3, 3, mkupd(16'h0FFF, 1, 12, 24, 1'b1, 2'b00),
             mkupd(16'hFFFF, 2, 0, 20, 1'b1, 2'b00), 0, 4, '0);
        // R9: zero length and clamping above 16
        send("R9", 3, 2, mkupd(16'h1111, 0, 4, 0, 1'b1, 2'b00), 0, 0, 0, '0);
        send("R9", 31, 0, 0, 0, 0, 20, mkhdr(7));
        // R11: unused mode codes pass through
        send("R11", 3, 5, mkupd(16'hFFFF, 0, 0, 0, 1'b1, 2'b00), 0, 0, 3, mkhdr(21));
        send("R11", 3, 7, mkupd(16'hFFFF, 0, 0, 0, 1'b1, 2'b00), 0, 0, 4, mkhdr(22));
        // R10: random mix under back-pressure
        stall_en = 1'b1;
        for (int s = 0; s < 32; s++)
            send("R3", s, 1, 0, 0, 0, s % 17, mkhdr(32'(100 + s)));
        for (int i = 0; i < 60; i++)
            send("R4", int'($urandom_range(31)), int'($urandom_range(7)),
                 $urandom, $urandom, $urandom, int'($urandom_range(20)),
                 mkhdr($urandom));
        stall_en = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule